// File: doc/BRIEF.md
# Breathing and Blinking LED Controller

A single-channel LED driver that produces a pulse-width modulated output in one of four modes: forced low, a brightness ramp ("breathe"), a fixed-duty flash ("blink") and forced high. In blink mode an 8-bit PWM counter advances on the terminal count of a prescaler. That prescaler is fed either by a slow reference tick strobe or by the system clock. In breathe mode the PWM counter advances on every slow tick, and a ramp engine moves the current duty between a lower and an upper limit, pausing at each end.

The ramp is split into eight segments, chosen by the top three bits of the current duty. Each segment has its own step size and its own update interval. The falling ramp may optionally use a separate set of steps and intervals. Configuration is written through a simple write port. While the output is modulating, new values wait in holding registers. They move into the active set at the next PWM period end, once an update has been requested.

Top module: `led_pulse_ctrl`

## Requirements
- R1: Control register (address 0) bits [3:2] select the mode. 0 drives `led_o` low, 3 drives it high, 1 is breathe and 2 is blink.
- R2: In blink mode the period is 256 counts and `led_o` is high while the count is below the blink duty. Address 7 holds the duty in [7:0] and the prescaler in [31:16]. A prescaler value N advances the count once every N+1 selected clocks.
- R3: Control bit 6 selects the blink clock: 0 is the slow tick, 1 is the system clock. A change takes effect at once, without an update request.
- R4: Control bits [5:4] select the breathe resolution: 0 gives 256 counts, 1 gives 128, and 2 or 3 gives 64. A change takes effect at once.
- R5: Address 1 holds the lower limit in [7:0] and the upper limit in [15:8]. The ramp segment is the top three bits of the duty at the selected resolution. Segment k uses nibble [4k+3:4k] of the step register (address 3) and of the interval register (address 4). An interval of N changes the duty once every N+1 periods, and each step saturates at the limits.
- R6: Address 2 holds the low pause in [11:0] and the high pause in [27:16]. On entry to breathe the duty starts at the lower limit and waits the low pause. When the duty is at or above the upper limit, it waits the high pause and then ramps down. When it is at or below the lower limit, it waits the low pause and then ramps up.
- R7: With control bit 1 clear, the falling ramp uses addresses 3 and 4. With it set, the falling ramp uses address 5 for steps and address 6 for intervals.
- R8: In blink or breathe mode, writes to addresses 1 to 7 do not affect the output. Writing control bit 7 raises `upd_pending_o`. At the next PWM period end the held values become active and `upd_pending_o` falls.
- R9: In off or on mode, writes to addresses 1 to 7 become active at once, and `upd_pending_o` stays low even when bit 7 is written.
- R10: Writing control bit 0 returns every register to its default and selects off mode. `wdt_reload_o` shows control bits [15:8], which default to 0x14.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | System clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| slow_tick_i | input | 1 | One-cycle strobe of the slow reference clock |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 3 | Register address |
| wr_data_i | input | 32 | Register write data |
| led_o | output | 1 | LED drive |
| duty_o | output | 8 | Active duty: ramp duty in breathe, blink duty in blink, 0 otherwise |
| upd_pending_o | output | 1 | Update request outstanding |
| wdt_reload_o | output | 8 | Watchdog reload field |

## Verification
The bench uses the default widths: an 8-bit duty, 12-bit pauses and a 16-bit prescaler. It runs the ramp at the 6-bit resolution with a slow tick on every cycle, which makes a breathe period 64 clocks. That keeps a full up-pause-down-pause cycle short enough to check every duty change and the number of whole periods between changes. Blink checks use small prescaler values and a tick on every fourth cycle. Because the output is periodic, counting high cycles over one full period checks the duty, the prescaler and the clock select regardless of phase.

// File: rtl/led_pkg.sv
package led_pkg;
  localparam int unsigned DUTY_W = 8;
  localparam int unsigned NSEG   = 8;
  localparam int unsigned SEG_W  = $clog2(NSEG);
  localparam int unsigned NIB_W  = 4;
  localparam int unsigned DLY_W  = 12;
  localparam int unsigned PS_W   = 16;
  localparam int unsigned REG_W  = 32;
  localparam int unsigned ADDR_W = 3;
  localparam int unsigned WDT_W  = 8;

  // control bit positions
  localparam int unsigned CB_SRST = 0;
  localparam int unsigned CB_ASYM = 1;
  localparam int unsigned CB_MODE = 2;
  localparam int unsigned CB_RES  = 4;
  localparam int unsigned CB_CSEL = 6;
  localparam int unsigned CB_UPD  = 7;
  localparam int unsigned CB_WDT  = 8;

  localparam logic [ADDR_W-1:0] A_CTRL  = 3'd0;
  localparam logic [ADDR_W-1:0] A_LIM   = 3'd1;
  localparam logic [ADDR_W-1:0] A_DLY   = 3'd2;
  localparam logic [ADDR_W-1:0] A_USTEP = 3'd3;
  localparam logic [ADDR_W-1:0] A_UIV   = 3'd4;
  localparam logic [ADDR_W-1:0] A_DSTEP = 3'd5;
  localparam logic [ADDR_W-1:0] A_DIV   = 3'd6;
  localparam logic [ADDR_W-1:0] A_BLINK = 3'd7;

  typedef enum logic [1:0] {
    MODE_OFF = 2'd0, MODE_BREATHE = 2'd1, MODE_BLINK = 2'd2, MODE_ON = 2'd3
  } mode_e;

  typedef struct packed {
    logic [WDT_W-1:0] wdt;
    mode_e            mode;
    logic [1:0]       res;
    logic             csel;
    logic             asym;
  } ctrl_t;

  typedef struct packed {
    logic [DUTY_W-1:0]     lo_lim;
    logic [DUTY_W-1:0]     hi_lim;
    logic [DLY_W-1:0]      lo_dly;
    logic [DLY_W-1:0]      hi_dly;
    logic [NSEG*NIB_W-1:0] up_step;
    logic [NSEG*NIB_W-1:0] up_iv;
    logic [NSEG*NIB_W-1:0] dn_step;
    logic [NSEG*NIB_W-1:0] dn_iv;
    logic [DUTY_W-1:0]     bl_duty;
    logic [PS_W-1:0]       bl_ps;
  } cfg_t;

  function automatic logic [1:0] res_shift(input logic [1:0] res);
    return (res == 2'd3) ? 2'd2 : res;
  endfunction

  function automatic logic [DUTY_W-1:0] res_top(input logic [1:0] res);
    return {DUTY_W{1'b1}} >> res_shift(res);
  endfunction
endpackage

// File: rtl/led_regs.sv
module led_regs
  import led_pkg::*;
#(
  parameter logic [WDT_W-1:0] WDT_DFLT = 8'h14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  input  logic              period_end_i,
  output ctrl_t             ctrl_o,
  output cfg_t              act_o,
  output logic              pend_o
);
  localparam ctrl_t CTRL_DFLT = '{wdt: WDT_DFLT, mode: MODE_OFF, res: 2'd0, csel: 1'b0, asym: 1'b0};

  ctrl_t ctrl_q;
  cfg_t  hold_q, hold_d, act_q;
  logic  pend_q;

  logic ctrl_wr, srst, live;
  assign ctrl_wr = wr_en_i && (wr_addr_i == A_CTRL);
  assign srst    = ctrl_wr && wr_data_i[CB_SRST];
  assign live    = (ctrl_q.mode == MODE_BREATHE) || (ctrl_q.mode == MODE_BLINK);

  always_comb begin
    hold_d = hold_q;
    if (wr_en_i) begin
      unique case (wr_addr_i)
        A_LIM: begin
          hold_d.lo_lim = wr_data_i[DUTY_W-1:0];
          hold_d.hi_lim = wr_data_i[DUTY_W +: DUTY_W];
        end
        A_DLY: begin
          hold_d.lo_dly = wr_data_i[DLY_W-1:0];
          hold_d.hi_dly = wr_data_i[16 +: DLY_W];
        end
        A_USTEP: hold_d.up_step = wr_data_i[NSEG*NIB_W-1:0];
        A_UIV:   hold_d.up_iv   = wr_data_i[NSEG*NIB_W-1:0];
        A_DSTEP: hold_d.dn_step = wr_data_i[NSEG*NIB_W-1:0];
        A_DIV:   hold_d.dn_iv   = wr_data_i[NSEG*NIB_W-1:0];
        A_BLINK: begin
          hold_d.bl_duty = wr_data_i[DUTY_W-1:0];
          hold_d.bl_ps   = wr_data_i[16 +: PS_W];
        end
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= CTRL_DFLT;
      hold_q <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
    end else if (srst) begin
      ctrl_q <= CTRL_DFLT;
      hold_q <= '0;
      act_q  <= '0;
      pend_q <= 1'b0;
    end else begin
      hold_q <= hold_d;
      if (ctrl_wr) begin
        ctrl_q.wdt  <= wr_data_i[CB_WDT +: WDT_W];
        ctrl_q.mode <= mode_e'(wr_data_i[CB_MODE +: 2]);
        ctrl_q.res  <= wr_data_i[CB_RES +: 2];
        ctrl_q.csel <= wr_data_i[CB_CSEL];
        ctrl_q.asym <= wr_data_i[CB_ASYM];
      end
      if (!live) begin
        // static modes: writes land directly, nothing to hand over
        act_q  <= hold_d;
        pend_q <= 1'b0;
      end else begin
        if (pend_q && period_end_i) begin
          act_q  <= hold_q;
          pend_q <= 1'b0;
        end
        if (ctrl_wr && wr_data_i[CB_UPD]) pend_q <= 1'b1;
      end
    end
  end

  assign ctrl_o = ctrl_q;
  assign act_o  = act_q;
  assign pend_o = pend_q;
endmodule

// File: rtl/led_pwm.sv
module led_pwm
  import led_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  mode_e             mode_i,
  input  logic [1:0]        res_i,
  input  logic              csel_i,
  input  logic              slow_tick_i,
  input  logic [PS_W-1:0]   ps_i,
  input  logic [DUTY_W-1:0] cmp_i,
  output logic              hi_o,
  output logic              period_end_o
);
  logic [PS_W-1:0]   ps_cnt_q;
  logic [DUTY_W-1:0] cnt_q, top;
  logic blink, breathe, tick, ps_done, adv, wrap;

  assign blink   = (mode_i == MODE_BLINK);
  assign breathe = (mode_i == MODE_BREATHE);
  assign tick    = blink ? (csel_i | slow_tick_i) : (breathe & slow_tick_i);
  assign ps_done = blink ? (ps_cnt_q >= ps_i) : 1'b1;
  assign adv     = tick && ps_done;
  assign top     = blink ? {DUTY_W{1'b1}} : res_top(res_i);
  // >= so a resolution cut mid-period wraps on the next advance
  assign wrap    = (cnt_q >= top);
  assign period_end_o = adv && wrap;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ps_cnt_q <= '0;
      cnt_q    <= '0;
    end else if (!(blink || breathe)) begin
      ps_cnt_q <= '0;
      cnt_q    <= '0;
    end else begin
      if (tick) ps_cnt_q <= ps_done ? '0 : ps_cnt_q + 1'b1;
      if (adv)  cnt_q    <= wrap ? '0 : cnt_q + 1'b1;
    end
  end

  assign hi_o = (cnt_q < cmp_i);
endmodule

// File: rtl/led_ramp.sv
module led_ramp
  import led_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              en_i,
  input  logic              period_end_i,
  input  logic [1:0]        res_i,
  input  logic              asym_i,
  input  cfg_t              cfg_i,
  output logic [DUTY_W-1:0] duty_o
);
  logic [NIB_W-1:0] up_step [NSEG];
  logic [NIB_W-1:0] up_iv   [NSEG];
  logic [NIB_W-1:0] dn_step [NSEG];
  logic [NIB_W-1:0] dn_iv   [NSEG];

  for (genvar k = 0; k < NSEG; k++) begin : g_seg
    assign up_step[k] = cfg_i.up_step[k*NIB_W +: NIB_W];
    assign up_iv[k]   = cfg_i.up_iv[k*NIB_W +: NIB_W];
    assign dn_step[k] = asym_i ? cfg_i.dn_step[k*NIB_W +: NIB_W] : cfg_i.up_step[k*NIB_W +: NIB_W];
    assign dn_iv[k]   = asym_i ? cfg_i.dn_iv[k*NIB_W +: NIB_W]   : cfg_i.up_iv[k*NIB_W +: NIB_W];
  end

  logic [DUTY_W-1:0] duty_q, top, hi_lim, lo_lim, nxt;
  logic [DLY_W-1:0]  hold_q;
  logic [NIB_W-1:0]  iv_cnt_q, step, iv;
  logic [SEG_W-1:0]  seg;
  logic              up_q;
  logic [DUTY_W:0]   sum, floor_sum;

  assign top    = res_top(res_i);
  assign hi_lim = (cfg_i.hi_lim > top) ? top : cfg_i.hi_lim;
  assign lo_lim = (cfg_i.lo_lim > hi_lim) ? hi_lim : cfg_i.lo_lim;
  assign seg    = SEG_W'(duty_q >> (DUTY_W - SEG_W - res_shift(res_i)));
  assign step   = up_q ? up_step[seg] : dn_step[seg];
  assign iv     = up_q ? up_iv[seg]   : dn_iv[seg];

  always_comb begin
    sum       = {1'b0, duty_q} + (DUTY_W+1)'(step);
    floor_sum = {1'b0, lo_lim} + (DUTY_W+1)'(step);
    if (up_q) nxt = (sum >= {1'b0, hi_lim}) ? hi_lim : sum[DUTY_W-1:0];
    else      nxt = ({1'b0, duty_q} <= floor_sum) ? lo_lim : duty_q - DUTY_W'(step);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      duty_q   <= '0;
      up_q     <= 1'b1;
      hold_q   <= '0;
      iv_cnt_q <= '0;
    end else if (!en_i) begin
      duty_q   <= lo_lim;
      up_q     <= 1'b1;
      hold_q   <= cfg_i.lo_dly;
      iv_cnt_q <= '0;
    end else if (period_end_i) begin
      if (hold_q != '0) begin
        hold_q <= hold_q - 1'b1;
      end else if (up_q && duty_q >= hi_lim) begin
        up_q   <= 1'b0;
        hold_q <= cfg_i.hi_dly;
      end else if (!up_q && duty_q <= lo_lim) begin
        up_q   <= 1'b1;
        hold_q <= cfg_i.lo_dly;
      end else if (iv_cnt_q < iv) begin
        iv_cnt_q <= iv_cnt_q + 1'b1;
      end else begin
        iv_cnt_q <= '0;
        duty_q   <= nxt;
      end
    end
  end

  assign duty_o = duty_q;
endmodule

// File: rtl/led_pulse_ctrl.sv
module led_pulse_ctrl
  import led_pkg::*;
#(
  parameter logic [WDT_W-1:0] WDT_DFLT = 8'h14
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              slow_tick_i,
  input  logic              wr_en_i,
  input  logic [ADDR_W-1:0] wr_addr_i,
  input  logic [REG_W-1:0]  wr_data_i,
  output logic              led_o,
  output logic [DUTY_W-1:0] duty_o,
  output logic              upd_pending_o,
  output logic [WDT_W-1:0]  wdt_reload_o
);
  ctrl_t             ctrl_q;
  cfg_t              act;
  logic              period_end, pwm_hi, breathe, blink;
  logic [DUTY_W-1:0] ramp_duty, cmp;

  led_regs #(.WDT_DFLT(WDT_DFLT)) u_regs (
    .clk_i, .rst_ni, .wr_en_i, .wr_addr_i, .wr_data_i,
    .period_end_i(period_end), .ctrl_o(ctrl_q), .act_o(act), .pend_o(upd_pending_o)
  );

  assign breathe = (ctrl_q.mode == MODE_BREATHE);
  assign blink   = (ctrl_q.mode == MODE_BLINK);
  assign cmp     = breathe ? ramp_duty : act.bl_duty;

  led_pwm u_pwm (
    .clk_i, .rst_ni, .mode_i(ctrl_q.mode), .res_i(ctrl_q.res), .csel_i(ctrl_q.csel),
    .slow_tick_i, .ps_i(act.bl_ps), .cmp_i(cmp), .hi_o(pwm_hi), .period_end_o(period_end)
  );

  led_ramp u_ramp (
    .clk_i, .rst_ni, .en_i(breathe), .period_end_i(period_end), .res_i(ctrl_q.res),
    .asym_i(ctrl_q.asym), .cfg_i(act), .duty_o(ramp_duty)
  );

  assign led_o        = (ctrl_q.mode == MODE_ON) || ((breathe || blink) && pwm_hi);
  assign duty_o       = breathe ? ramp_duty : (blink ? act.bl_duty : '0);
  assign wdt_reload_o = ctrl_q.wdt;
endmodule

// File: rtl/led_pulse_ctrl_chk.sv
module led_pulse_ctrl_chk
  import led_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              wr_en_i,
  input logic [ADDR_W-1:0] wr_addr_i,
  input logic [REG_W-1:0]  wr_data_i,
  input logic              led_o,
  input logic [DUTY_W-1:0] duty_o,
  input logic              upd_pending_o,
  input mode_e             mode,
  input logic              period_end
);
  logic ctrl_wr, live;
  assign ctrl_wr = wr_en_i && (wr_addr_i == A_CTRL);
  assign live    = (mode == MODE_BREATHE) || (mode == MODE_BLINK);

  AST_OFF_LOW: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && !wr_data_i[CB_SRST] && wr_data_i[CB_MODE +: 2] == 2'd0 |=> !led_o); // R1
  AST_ON_HIGH: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && !wr_data_i[CB_SRST] && wr_data_i[CB_MODE +: 2] == 2'd3 |=> led_o); // R1
  AST_DUTY_AT_BOUNDARY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mode == MODE_BREATHE && $past(mode) == MODE_BREATHE && duty_o != $past(duty_o)
    |-> $past(period_end)); // R5
  AST_PEND_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && !wr_data_i[CB_SRST] && wr_data_i[CB_UPD] && live |=> upd_pending_o); // R8
  AST_PEND_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(upd_pending_o) |-> $past(period_end) || !$past(live) || $past(ctrl_wr && wr_data_i[CB_SRST])); // R8
  AST_STATIC_NO_PEND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !live |=> !upd_pending_o); // R9
  AST_SOFT_RESET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ctrl_wr && wr_data_i[CB_SRST] |=> !led_o && !upd_pending_o && duty_o == '0); // R10
endmodule

bind led_pulse_ctrl led_pulse_ctrl_chk u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .wr_en_i(wr_en_i), .wr_addr_i(wr_addr_i),
  .wr_data_i(wr_data_i), .led_o(led_o), .duty_o(duty_o), .upd_pending_o(upd_pending_o),
  .mode(ctrl_q.mode), .period_end(period_end)
);

// File: tb/tb_led_pulse_ctrl.sv
module tb_led_pulse_ctrl;
  localparam int CLK_PERIOD = 10;
  localparam int BR_PER     = 64;

  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic        slow_tick_i = 1'b0;
  logic        wr_en_i = 1'b0;
  logic [2:0]  wr_addr_i = '0;
  logic [31:0] wr_data_i = '0;
  logic        led_o;
  logic [7:0]  duty_o;
  logic        upd_pending_o;
  logic [7:0]  wdt_reload_o;

  led_pulse_ctrl dut (.*);

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  int checks = 0, errors = 0;
  int tick_every = 1, tick_div = 0;
  int cyc = 0;
  bit done = 0;

  always @(negedge clk_i) begin
    tick_div    = (tick_div + 1) % tick_every;
    slow_tick_i = (tick_div == 0);
  end

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // scoreboard of breathe duty changes: value and gap in whole periods (-1: ignore gap)
  typedef struct {int val; int gap; string req;} item_t;
  item_t sb_q[$];
  bit    mon_en = 0;
  int    last_duty = 0, last_cyc = 0;

  task automatic push(int val, int gap, string req);
    item_t it;
    it.val = val; it.gap = gap; it.req = req;
    sb_q.push_back(it);
  endtask

  always @(negedge clk_i) begin
    cyc++;
    if (mon_en && int'(duty_o) != last_duty) begin
      if (sb_q.size() == 0) chk("R5 unexpected change", int'(duty_o), last_duty);
      else begin
        item_t it;
        it = sb_q.pop_front();
        chk(it.req, int'(duty_o), it.val);
        if (it.gap >= 0) chk({it.req, " gap"}, cyc - last_cyc, it.gap * BR_PER);
      end
      last_cyc = cyc;
    end
    last_duty = int'(duty_o);
  end

  task automatic wr(logic [2:0] a, logic [31:0] d);
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk_i);
    wr_en_i = 1'b0;
  endtask

  function automatic logic [31:0] cw(int mode, int res, int csel, int asym, int upd, int wdt);
    return (32'(wdt) << 8) | (32'(upd) << 7) | (32'(csel) << 6) | (32'(res) << 4)
         | (32'(mode) << 2) | (32'(asym) << 1);
  endfunction

  task automatic highs(int n, output int c);
    c = 0;
    repeat (n) begin
      @(negedge clk_i);
      c += int'(led_o);
    end
  endtask

  task automatic wait_clear();
    int k = 0;
    while (upd_pending_o && k < 5000) begin
      @(negedge clk_i);
      k++;
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int c;
    repeat (3) @(negedge clk_i);
    rst_ni = 1'b1;
    @(negedge clk_i);
    chk("R1 reset led", led_o, 0);
    chk("R10 reset pending", upd_pending_o, 0);
    chk("R10 reset wdt", wdt_reload_o, 8'h14);
    chk("R10 reset duty", duty_o, 0);

    wr(3'd0, cw(0, 0, 0, 0, 0, 8'h14));
    highs(64, c); chk("R1 off low", c, 0);
    wr(3'd0, cw(3, 0, 0, 0, 0, 8'h14));
    highs(64, c); chk("R1 on high", c, 64);

    // static mode: direct write, update request ignored
    wr(3'd7, 32'h0000_0020);
    wr(3'd0, cw(3, 0, 0, 0, 1, 8'h14));
    chk("R9 no pending in on mode", upd_pending_o, 0);
    wr(3'd0, cw(2, 0, 1, 0, 0, 8'h14));
    chk("R9 duty live at entry", duty_o, 32);
    highs(256, c); chk("R2 blink duty 32", c, 32);

    // shadowed write in blink
    wr(3'd7, 32'h0000_0080);
    chk("R8 held duty not live", duty_o, 32);
    highs(256, c); chk("R8 output unchanged", c, 32);
    chk("R8 no pending yet", upd_pending_o, 0);
    wr(3'd0, cw(2, 0, 1, 0, 1, 8'h14));
    chk("R8 pending raised", upd_pending_o, 1);
    wait_clear();
    chk("R8 pending cleared", upd_pending_o, 0);
    chk("R8 duty loaded", duty_o, 128);
    highs(256, c); chk("R2 blink duty 128", c, 128);

    // prescaler 1 halves the rate
    wr(3'd7, 32'h0001_0080);
    wr(3'd0, cw(2, 0, 1, 0, 1, 8'h14));
    wait_clear();
    highs(512, c); chk("R2 prescaler 1", c, 256);

    // slow tick every 4th clock
    tick_every = 4;
    wr(3'd0, cw(2, 0, 0, 0, 0, 8'h14));
    highs(2048, c); chk("R3 slow tick source", c, 1024);
    wr(3'd0, cw(2, 0, 1, 0, 0, 8'h14));
    highs(512, c); chk("R3 system clock immediate", c, 256);
    tick_every = 1;

    // watchdog field and soft reset
    wr(3'd0, cw(0, 0, 0, 0, 0, 8'h5A));
    chk("R10 wdt written", wdt_reload_o, 8'h5A);
    wr(3'd0, 32'h0000_0001);
    chk("R10 wdt default", wdt_reload_o, 8'h14);
    chk("R10 led low", led_o, 0);
    wr(3'd0, cw(2, 0, 1, 0, 0, 8'h14));
    chk("R10 blink duty default", duty_o, 0);
    highs(256, c); chk("R10 blink output after reset", c, 0);
    wr(3'd0, cw(0, 0, 0, 0, 0, 8'h14));

    // breathe ramp at 6-bit resolution, asymmetric
    wr(3'd1, 32'h0000_1404);
    wr(3'd2, 32'h0002_0001);
    wr(3'd3, 32'h0000_0153);
    wr(3'd4, 32'h0000_0010);
    wr(3'd5, 32'h0000_0621);
    wr(3'd6, 32'h0000_0000);
    push(4,  -1, "R6 entry at lower limit");
    push(7,   2, "R6 low pause then R5 step seg0");
    push(10,  1, "R5 step seg0");
    push(15,  2, "R5 interval seg1");
    push(20,  2, "R5 saturate upper R4");
    push(14,  4, "R6 high pause then R7 down step seg2");
    push(12,  1, "R7 down seg1");
    push(10,  1, "R7 down seg1");
    push(8,   1, "R7 down seg1");
    push(6,   1, "R7 down seg1");
    push(5,   1, "R7 down seg0");
    push(4,   1, "R5 saturate lower");
    push(7,   3, "R6 low pause before rise");
    mon_en = 1;
    @(negedge clk_i);
    wr_en_i = 1'b1; wr_addr_i = 3'd0; wr_data_i = cw(1, 2, 0, 1, 0, 8'h14);
    @(negedge clk_i);
    wr_en_i = 1'b0;
    begin
      int k = 0;
      while (sb_q.size() != 0 && k < 4000) begin
        @(negedge clk_i);
        k++;
      end
    end
    mon_en = 0;
    chk("R5 all ramp items seen", sb_q.size(), 0);

    wr(3'd0, cw(0, 0, 0, 0, 0, 8'h14));
    chk("R1 back to off", led_o, 0);

    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule